// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Source Select

This block generates the clock enable for one peripheral. Ten single-cycle source enable inputs are offered to it: a fixed ground, the crystal oscillator enable, two test-debug enables and six instance-specific enables. A select field in the control word picks one of them. The chosen pulse stream is then divided by a fixed-point ratio taken from the divider word. The integer part of that ratio sits from bit 12 upward, and the fraction sits just below bit 12.

The divider is a phase accumulator. Every selected source pulse adds one unit, equal to 2^FRAC_W. Whenever the sum reaches the divide value, the divide value is taken off the sum and one output enable pulse is emitted. Over time the output rate is the source rate times 2^FRAC_W divided by the divide value. The integer and fraction widths are parameters. With both widths zero the block passes the selected source straight through. A registered busy bit follows the enable bit of the control word.

Top module: `clkgen_fracdiv`

## Requirements
- R1: The source select is ctl_word[3:0]. Value 0 is ground (no pulses). Value 1 selects osc_en, 2 selects tdbg_en[0], 3 selects tdbg_en[1], and 4 to 9 select inst_en[0] to inst_en[5]. Values 10 to 15 behave as ground.
- R2: The enable is ctl_word[4]. While it is 0, clk_en_out stays 0 and the accumulator is cleared.
- R3: After each clock edge, busy equals the enable bit sampled at that edge. Both are 0 out of reset.
- R4: The divide value D is div_word[12+INT_W-1 : 12-FRAC_W]; with the defaults (INT_W=4, FRAC_W=4) this is div_word[15:8]. All other bits of div_word have no effect.
- R5: Each selected, enabled source pulse adds 2^FRAC_W to the accumulator. When the sum is at least D, one output pulse is emitted and D is subtracted from the sum. When D is not above 2^FRAC_W, every source pulse yields an output pulse.
- R6: When the widths are non-zero and D is 0, clk_en_out stays 0.
- R7: When INT_W and FRAC_W are both 0, clk_en_out repeats the enabled, selected source pulse and ignores div_word.
- R8: Pulses on sources that are not selected change neither the output nor the accumulator.
- R9: A change of the select value clears the accumulator. A selected pulse arriving in the same cycle as the change is dropped.
- R10: An output pulse appears on the clock edge that samples the source pulse causing it, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Crystal oscillator enable pulse (source 1) |
| tdbg_en | input | 2 | Test-debug enable pulses (sources 2, 3) |
| inst_en | input | INST_SRC | Instance-specific enable pulses (sources 4 to 9) |
| ctl_word | input | 8 | Source select [3:0] and enable [4] |
| div_word | input | 32 | Divider word, integer part from bit 12 and fraction below it |
| clk_en_out | output | 1 | Divided clock enable pulse |
| busy | output | 1 | Registered enable state |

## Verification
The output pulse and busy are both registered once. Each is therefore due on the first clock edge after the inputs that cause it. The reset synchronizer adds two further edges after rst_n rises. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, so every result is taken exactly one edge after its stimulus. Pulse-count vectors add up the output over a window that also covers the edge after the last source pulse.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int CTL_W     = 8;
  localparam int SEL_LSB   = 0;
  localparam int SEL_W     = 4;
  localparam int EN_BIT    = 4;
  localparam int DIVW_W    = 32;
  localparam int INT_LSB   = 12;
  localparam int FIXED_SRC = 4;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.en  = w[EN_BIT];
    c.sel = w[SEL_LSB +: SEL_W];
    return c;
  endfunction
endpackage

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/clkgen_src_select.sv
module clkgen_src_select #(
  parameter int NUM_SRC = 10,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0] srcs,
  input  logic [SEL_W-1:0]   sel,
  output logic               sel_pulse
);
  always_comb begin
    sel_pulse = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) sel_pulse = srcs[i];
    end
  end
endmodule

// File: rtl/clkgen_phase_acc.sv
module clkgen_phase_acc #(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 4,
  localparam int DV_W  = (INT_W + FRAC_W > 0) ? INT_W + FRAC_W : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic            step,
  input  logic [DV_W-1:0] div_val,
  output logic            pulse_q
);
  generate
    if (INT_W + FRAC_W == 0) begin : g_pass
      logic unused_pass;
      assign unused_pass = ^{clr, div_val};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= en & step;
      end
    end else begin : g_acc
      localparam int ACC_W = INT_W + FRAC_W + 1;
      localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

      logic [ACC_W-1:0] acc_q, acc_d, sum, dv;
      logic             pulse_d;

      always_comb begin
        dv      = {1'b0, div_val};
        sum     = acc_q + UNIT;
        acc_d   = acc_q;
        pulse_d = 1'b0;
        if (!en || clr || dv == '0) begin
          acc_d = '0;
        end else if (step) begin
          if (dv <= UNIT) begin
            pulse_d = 1'b1;
            acc_d   = '0;
          end else if (sum >= dv) begin
            pulse_d = 1'b1;
            acc_d   = sum - dv;
          end else begin
            acc_d   = sum;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q   <= '0;
          pulse_q <= 1'b0;
        end else begin
          acc_q   <= acc_d;
          pulse_q <= pulse_d;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/clkgen_fracdiv.sv
module clkgen_fracdiv #(
  parameter int INT_W    = 4,
  parameter int FRAC_W   = 4,
  parameter int INST_SRC = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osc_en,
  input  logic [1:0]                 tdbg_en,
  input  logic [INST_SRC-1:0]        inst_en,
  input  logic [clkgen_pkg::CTL_W-1:0]  ctl_word,
  input  logic [clkgen_pkg::DIVW_W-1:0] div_word,
  output logic                       clk_en_out,
  output logic                       busy
);
  import clkgen_pkg::*;

  localparam int NUM_SRC = FIXED_SRC + INST_SRC;
  localparam int DV_W    = (INT_W + FRAC_W > 0) ? INT_W + FRAC_W : 1;

  logic             rst_sync_n;
  ctl_t             ctl;
  logic [NUM_SRC-1:0] srcs;
  logic             sel_pulse;
  logic [SEL_W-1:0] sel_q;
  logic             sel_chg;
  logic [DV_W-1:0]  div_val;
  logic             unused_bits;

  assign ctl     = decode_ctl(ctl_word);
  assign srcs    = {inst_en, tdbg_en, osc_en, 1'b0};
  assign sel_chg = (ctl.sel != sel_q);

  generate
    if (INT_W + FRAC_W == 0) begin : g_nodiv
      assign div_val     = '0;
      assign unused_bits = ^{ctl_word[CTL_W-1:EN_BIT+1], div_word};
    end else begin : g_div
      assign div_val     = div_word[INT_LSB+INT_W-1 : INT_LSB-FRAC_W];
      assign unused_bits = ^{ctl_word[CTL_W-1:EN_BIT+1],
                             div_word[DIVW_W-1:INT_LSB+INT_W],
                             div_word[INT_LSB-FRAC_W-1:0]};
    end
  endgenerate

  clkgen_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  clkgen_src_select #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .srcs      (srcs),
    .sel       (ctl.sel),
    .sel_pulse (sel_pulse)
  );

  clkgen_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (ctl.en),
    .clr     (sel_chg),
    .step    (sel_pulse),
    .div_val (div_val),
    .pulse_q (clk_en_out)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= '0;
      busy  <= 1'b0;
    end else begin
      sel_q <= ctl.sel;
      busy  <= ctl.en;
    end
  end
endmodule

// File: rtl/clkgen_fracdiv_chk.sv
module clkgen_fracdiv_chk #(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 4
) (
  input logic        clk,
  input logic        rst_n_s,
  input logic [7:0]  ctl_word,
  input logic [31:0] div_word,
  input logic        sel_pulse,
  input logic        clk_en_out,
  input logic        busy
);
  logic       en;
  logic [3:0] sel;
  assign en  = ctl_word[4];
  assign sel = ctl_word[3:0];

  a_r3_busy_sets: assert property (@(posedge clk) disable iff (!rst_n_s)
    en |=> busy);
  a_r3_busy_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en |=> !busy);
  a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en |=> !clk_en_out);
  a_r10_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n_s)
    clk_en_out |-> $past(en && sel_pulse));

  generate
    if (INT_W + FRAC_W > 0) begin : g_div
      logic [INT_W+FRAC_W:0] dv;
      assign dv = {1'b0, div_word[12+INT_W-1 : 12-FRAC_W]};
      a_r6_zero_div_stops: assert property (@(posedge clk) disable iff (!rst_n_s)
        (dv == '0) |=> !clk_en_out);
      a_r5_fast_ratio: assert property (@(posedge clk) disable iff (!rst_n_s)
        (en && sel_pulse && $stable(sel) && dv != '0 && dv <= ((INT_W+FRAC_W+1)'(1) << FRAC_W))
        |=> clk_en_out);
    end else begin : g_pass
      a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n_s)
        (en && sel_pulse) |=> clk_en_out);
    end
  endgenerate
endmodule

bind clkgen_fracdiv clkgen_fracdiv_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_sync_n),
  .ctl_word   (ctl_word),
  .div_word   (div_word),
  .sel_pulse  (sel_pulse),
  .clk_en_out (clk_en_out),
  .busy       (busy)
);

// File: tb/clkgen_fracdiv_test.sv
module clkgen_fracdiv_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b0;
  logic [1:0]  tdbg_en = '0;
  logic [5:0]  inst_en = '0;
  logic [7:0]  ctl_word = '0;
  logic [31:0] div_word = '0;
  logic        clk_en_out, busy, pt_out, pt_busy;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkgen_fracdiv uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .tdbg_en(tdbg_en),
    .inst_en(inst_en), .ctl_word(ctl_word), .div_word(div_word),
    .clk_en_out(clk_en_out), .busy(busy));

  clkgen_fracdiv #(.INT_W(0), .FRAC_W(0)) uut_pt (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .tdbg_en(tdbg_en),
    .inst_en(inst_en), .ctl_word(ctl_word), .div_word(div_word),
    .clk_en_out(pt_out), .busy(pt_busy));

  typedef struct packed {
    logic [3:0]  sel;
    logic        en;
    logic [31:0] div;
    logic [7:0]  n;
    logic [7:0]  expc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1'b1, 32'h0000_2000, 8'd20, 8'd10},  // R5 ratio 2.0
    '{4'd1,  1'b1, 32'h0000_1800, 8'd18, 8'd12},  // R5 ratio 1.5
    '{4'd4,  1'b1, 32'h0000_1000, 8'd10, 8'd10},  // R5 ratio 1.0
    '{4'd9,  1'b1, 32'h0000_0800, 8'd10, 8'd10},  // R5 ratio 0.5
    '{4'd2,  1'b1, 32'h0000_0000, 8'd10, 8'd0 },  // R6 zero divide
    '{4'd0,  1'b1, 32'h0000_1000, 8'd10, 8'd0 },  // R1 ground
    '{4'd3,  1'b1, 32'h0000_3000, 8'd21, 8'd7 },  // R5 ratio 3.0
    '{4'd12, 1'b1, 32'h0000_1000, 8'd10, 8'd0 },  // R1 out-of-range select
    '{4'd1,  1'b0, 32'h0000_1000, 8'd10, 8'd0 },  // R2 disabled
    '{4'd1,  1'b1, 32'hFFFF_FFFF, 8'd32, 8'd2 },  // R4 D=255 with junk bits
    '{4'd6,  1'b1, 32'hFFFF_20FF, 8'd20, 8'd10}   // R4 D=32 with junk bits
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic set_src(input logic o, input logic [1:0] t, input logic [5:0] i);
    osc_en = o; tdbg_en = t; inst_en = i;
  endtask

  task automatic set_ctl(input logic en, input logic [3:0] sel);
    ctl_word = {3'b000, en, sel};
  endtask

  task automatic run_vec(input vec_t v);
    int cnt = 0;
    @(negedge clk);
    set_src(1'b0, 2'b00, 6'h00);
    set_ctl(1'b0, v.sel);
    div_word = v.div;
    @(negedge clk);
    set_ctl(v.en, v.sel);
    for (int k = 0; k < int'(v.n); k++) begin
      set_src(1'b1, 2'b11, 6'h3F);
      @(negedge clk);
      if (clk_en_out) cnt++;
    end
    set_src(1'b0, 2'b00, 6'h00);
    @(negedge clk);
    if (clk_en_out) cnt++;
    chk(cnt == int'(v.expc), "R5 vector pulse count", cnt, int'(v.expc));
    set_ctl(1'b0, v.sel);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(clk_en_out == 1'b0, "R2 reset output", clk_en_out, 0);
    chk(busy == 1'b0, "R3 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && clk_en_out == 1'b0, "R3 after release", busy, 0);

    // R3 busy timing
    set_ctl(1'b1, 4'd1);
    #1 chk(busy == 1'b0, "R3 busy before edge", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R3 busy set", busy, 1);
    set_ctl(1'b0, 4'd1);
    @(negedge clk);
    chk(busy == 1'b0, "R3 busy clear", busy, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 latency, D = 1.0
    div_word = 32'h0000_1000;
    @(negedge clk); set_ctl(1'b1, 4'd1);
    @(negedge clk); set_src(1'b1, 2'b00, 6'h00);
    #1 chk(clk_en_out == 1'b0, "R10 not before edge", clk_en_out, 0);
    @(negedge clk); set_src(1'b0, 2'b00, 6'h00);
    chk(clk_en_out == 1'b1, "R10 pulse after edge", clk_en_out, 1);
    @(negedge clk);
    chk(clk_en_out == 1'b0, "R10 single cycle", clk_en_out, 0);

    // R8 unselected sources ignored, D = 3.0, select inst_en[0]
    set_ctl(1'b0, 4'd4); div_word = 32'h0000_3000;
    @(negedge clk); set_ctl(1'b1, 4'd4);
    set_src(1'b0, 2'b00, 6'h01);
    @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      set_src(1'b1, 2'b11, 6'h3E);
      @(negedge clk);
      if (clk_en_out) cnt++;
    end
    chk(cnt == 0, "R8 other sources no output", cnt, 0);
    set_src(1'b0, 2'b00, 6'h01);
    @(negedge clk);
    chk(clk_en_out == 1'b0, "R8 second selected pulse", clk_en_out, 0);
    @(negedge clk);
    set_src(1'b0, 2'b00, 6'h00);
    chk(clk_en_out == 1'b1, "R8 third selected pulse emits", clk_en_out, 1);

    // R9 select change clears accumulator, D = 2.0
    @(negedge clk); set_ctl(1'b0, 4'd1); div_word = 32'h0000_2000;
    @(negedge clk); set_ctl(1'b1, 4'd1); set_src(1'b1, 2'b00, 6'h00);
    @(negedge clk); set_src(1'b0, 2'b00, 6'h00); set_ctl(1'b1, 4'd2);
    chk(clk_en_out == 1'b0, "R9 first pulse no output", clk_en_out, 0);
    @(negedge clk); set_src(1'b0, 2'b01, 6'h00);
    @(negedge clk);
    chk(clk_en_out == 1'b0, "R9 cleared after select change", clk_en_out, 0);
    @(negedge clk); set_src(1'b0, 2'b00, 6'h00);
    chk(clk_en_out == 1'b1, "R9 emits on second pulse", clk_en_out, 1);

    // R2 disable clears accumulator
    @(negedge clk); set_src(1'b1, 2'b00, 6'h00); set_ctl(1'b1, 4'd1);
    @(negedge clk); set_src(1'b0, 2'b00, 6'h00); set_ctl(1'b0, 4'd1);
    @(negedge clk); set_ctl(1'b1, 4'd1); set_src(1'b1, 2'b00, 6'h00);
    @(negedge clk);
    chk(clk_en_out == 1'b0, "R2 cleared by disable", clk_en_out, 0);
    @(negedge clk); set_src(1'b0, 2'b00, 6'h00);
    chk(clk_en_out == 1'b1, "R2 emits after re-enable", clk_en_out, 1);

    // R7 pass-through instance, select inst_en[1], div_word zero
    @(negedge clk); set_ctl(1'b1, 4'd5); div_word = 32'h0;
    @(negedge clk); set_src(1'b0, 2'b00, 6'h02);
    @(negedge clk); chk(pt_out == 1'b1, "R7 pass pulse", pt_out, 1);
    set_src(1'b1, 2'b11, 6'h00);
    @(negedge clk); chk(pt_out == 1'b0, "R7 other source ignored", pt_out, 0);
    set_src(1'b0, 2'b00, 6'h02); div_word = 32'hFFFF_FFFF;
    @(negedge clk); chk(pt_out == 1'b1, "R7 divider ignored", pt_out, 1);
    set_ctl(1'b0, 4'd5);
    @(negedge clk); chk(pt_out == 1'b0, "R7 disabled", pt_out, 0);
    set_src(1'b0, 2'b00, 6'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule